// File: doc/BRIEF.md
# Multidrop-Capable Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes. It runs from the system clock and advances only on a one-cycle enable that pulses sixteen times per bit period. A high-to-low transition on the idle line starts a frame. The receiver confirms the start bit halfway through it and then samples each following bit once, in the middle of its period. A finished byte goes into a holding register, and a ready flag tells the host that a byte is waiting.

The receiver checks each frame for framing, parity, overrun and break conditions. The block also supports a multidrop mode, where the ninth bit is an address marker. A frame with that bit high is an address. It is always delivered, and it raises an address interrupt so that software can compare it with its own station address. Frames with the ninth bit low are data. They reach the holding register only while software has set the accept control. Otherwise they are dropped without any trace.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, `data_ready`, every status flag, `addr_irq` and `rx_data` are all 0.
- R2: A frame is received least significant bit first. After the stop bit is sampled, `rx_data` holds the byte and `data_ready` is 1.
- R3: `cfg_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `rx_data` above the configured length read as 0.
- R4: A low pulse on `rxd` that has ended before the mid-start sample (8 enable ticks after the falling edge) is a false start. It delivers no byte.
- R5: With `cfg_par_en` = 1 and multidrop off, one parity bit follows the data. `err_parity` is 1 when the parity is wrong: even parity when `cfg_par_odd` = 0, odd parity when it is 1.
- R6: A stop bit sampled low sets `err_frame` for that byte.
- R7: When every sampled bit of a frame is low, stop bit included, `brk_seen` and `err_frame` are both set. The receiver then waits for `rxd` to return high before it looks for a new start bit, so a held break yields exactly one byte.
- R8: A byte that completes while `data_ready` is still 1 sets `err_overrun`. That new byte is discarded and `rx_data` keeps the unread byte.
- R9: A `rd_pulse` clears `data_ready`, all status flags and `addr_irq`.
- R10: With `cfg_multidrop` = 1, a ninth bit follows the data. A ninth bit of 1 stores the byte, sets `addr_seen` and `addr_irq`, and never sets `err_parity`.
- R11: With `cfg_multidrop` = 1 and a ninth bit of 0, the byte is stored only when `cfg_accept` = 1 (`addr_seen` = 0). When `cfg_accept` = 0 the byte is dropped and `data_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulsing 16 times per bit period |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len | input | 2 | Data length select (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_multidrop | input | 1 | Ninth-bit address mode |
| cfg_accept | input | 1 | Accept data frames in multidrop mode |
| rd_pulse | input | 1 | Host read of the holding register |
| rx_data | output | 8 | Holding register |
| data_ready | output | 1 | Byte waiting in holding register |
| err_frame | output | 1 | Stop bit was low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Byte lost while holding register was full |
| brk_seen | output | 1 | Whole frame was low |
| addr_seen | output | 1 | Held byte is an address |
| addr_irq | output | 1 | Address byte arrived |

## Verification
The bench sends a short glitch that ends before the start bit's midpoint. A receiver that skips the confirmation sample would build a stray byte of ones from it. A held break is followed by a long quiet check. A receiver that re-arms on the still-low line would produce a second byte and flag an overrun. A second byte is sent before the first is read. A design that overwrote the holding register would lose the first byte. In multidrop mode the bench sends a data byte with accept clear and an address byte whose ninth bit would count as a parity error under normal checking. A gate or parity check placed wrongly shows up as a stray ready flag or a false parity error.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MAX_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAIT_HI
  } rx_state_e;

  typedef struct packed {
    logic [MAX_W-1:0] data;
    logic             par_bit;
    logic             stop_bit;
    logic             all_low;
  } rx_frame_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_bitfsm.sv
module uart_rx_bitfsm
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic [1:0] len_sel,
  input  logic      par_on,
  output logic      frame_done,
  output rx_frame_t frame
);
  localparam int CW  = $clog2(OVERSAMPLE);
  localparam int IW  = $clog2(MAX_W);
  localparam int MID = OVERSAMPLE/2 - 1;

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [MAX_W-1:0]  data_q, data_d;
  logic              par_q, par_d, stop_q, stop_d, low_q, low_d, done_q, done_d;
  logic [IW-1:0]     last_idx;
  logic              at_end;

  assign last_idx = IW'(len_sel) + IW'(4);
  assign at_end   = (cnt_q == CW'(OVERSAMPLE-1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    data_d  = data_q;
    par_d   = par_q;
    stop_d  = stop_q;
    low_d   = low_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (tick && !rxd) begin
        state_d = ST_START;
        cnt_d   = '0;
        data_d  = '0;
        par_d   = 1'b0;
        low_d   = 1'b1;
      end
      ST_START: if (tick) begin
        if (cnt_q == CW'(MID)) begin
          cnt_d = '0;
          idx_d = '0;
          state_d = rxd ? ST_IDLE : ST_DATA;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_DATA: if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (at_end) begin
          data_d[idx_q] = rxd;
          low_d = low_q & ~rxd;
          idx_d = idx_q + 1'b1;
          if (idx_q == last_idx) state_d = par_on ? ST_PAR : ST_STOP;
        end
      end
      ST_PAR: if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (at_end) begin
          par_d   = rxd;
          low_d   = low_q & ~rxd;
          state_d = ST_STOP;
        end
      end
      ST_STOP: if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (at_end) begin
          stop_d  = rxd;
          low_d   = low_q & ~rxd;
          done_d  = 1'b1;
          state_d = rxd ? ST_IDLE : ST_WAIT_HI;
        end
      end
      ST_WAIT_HI: if (rxd) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      par_q   <= 1'b0;
      stop_q  <= 1'b1;
      low_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      par_q   <= par_d;
      stop_q  <= stop_d;
      low_q   <= low_d;
      done_q  <= done_d;
    end
  end

  assign frame_done     = done_q;
  assign frame.data     = data_q;
  assign frame.par_bit  = par_q;
  assign frame.stop_bit = stop_q;
  assign frame.all_low  = low_q;

  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick && cnt_q == CW'(MID) && rxd) |=> (state_q == ST_IDLE && !done_q)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2
  AST_BREAK_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_HI && !rxd) |=> (state_q == ST_WAIT_HI)); // R7
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  rx_frame_t        frame,
  input  logic             par_on,
  input  logic             par_odd,
  input  logic             multidrop,
  input  logic             accept,
  input  logic             rd,
  output logic [MAX_W-1:0] rx_data,
  output logic             data_ready,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_overrun,
  output logic             brk_seen,
  output logic             addr_seen,
  output logic             addr_irq
);
  logic [MAX_W-1:0] data_q, data_d;
  logic rdy_q, rdy_d, fe_q, fe_d, pe_q, pe_d, oe_q, oe_d;
  logic bk_q, bk_d, as_q, as_d, ai_q, ai_d;
  logic is_addr, keep, occupied, par_bad;

  assign is_addr  = multidrop & frame.par_bit;
  assign keep     = ~multidrop | is_addr | accept;
  assign occupied = rdy_q & ~rd;
  assign par_bad  = par_on & ~multidrop & (^frame.data ^ frame.par_bit ^ par_odd);

  always_comb begin
    data_d = data_q;
    rdy_d  = rdy_q;
    fe_d   = fe_q;
    pe_d   = pe_q;
    oe_d   = oe_q;
    bk_d   = bk_q;
    as_d   = as_q;
    ai_d   = ai_q;
    if (rd) begin
      rdy_d = 1'b0;
      fe_d  = 1'b0;
      pe_d  = 1'b0;
      oe_d  = 1'b0;
      bk_d  = 1'b0;
      ai_d  = 1'b0;
    end
    if (frame_done && keep) begin
      if (occupied) oe_d = 1'b1;
      else begin
        data_d = frame.data;
        rdy_d  = 1'b1;
        fe_d   = ~frame.stop_bit;
        pe_d   = par_bad;
        bk_d   = frame.all_low;
        as_d   = is_addr;
        ai_d   = is_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      oe_q   <= 1'b0;
      bk_q   <= 1'b0;
      as_q   <= 1'b0;
      ai_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      rdy_q  <= rdy_d;
      fe_q   <= fe_d;
      pe_q   <= pe_d;
      oe_q   <= oe_d;
      bk_q   <= bk_d;
      as_q   <= as_d;
      ai_q   <= ai_d;
    end
  end

  assign rx_data     = data_q;
  assign data_ready  = rdy_q;
  assign err_frame   = fe_q;
  assign err_parity  = pe_q;
  assign err_overrun = oe_q;
  assign brk_seen    = bk_q;
  assign addr_seen   = as_q;
  assign addr_irq    = ai_q;

  AST_READY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && keep && !occupied) |=> data_ready); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !frame_done) |=> (!data_ready && !err_overrun && !addr_irq)); // R9
  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && keep && occupied) |=> (err_overrun && $stable(rx_data))); // R8
  AST_ADDR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && multidrop && frame.par_bit && !occupied) |=> (addr_irq && !err_parity)); // R10
  AST_DISCARD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && multidrop && !frame.par_bit && !accept && !rdy_q) |=> !data_ready); // R11
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_multidrop,
  input  logic       cfg_accept,
  input  logic       rd_pulse,
  output logic [7:0] rx_data,
  output logic       data_ready,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       brk_seen,
  output logic       addr_seen,
  output logic       addr_irq
);
  logic      rxd_s;
  logic      par_on;
  logic      done;
  rx_frame_t frame;

  assign par_on = cfg_par_en | cfg_multidrop;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  uart_rx_bitfsm #(.OVERSAMPLE(OVERSAMPLE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd_s),
    .len_sel(cfg_len), .par_on(par_on), .frame_done(done), .frame(frame)
  );

  uart_rx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .frame_done(done), .frame(frame),
    .par_on(par_on), .par_odd(cfg_par_odd), .multidrop(cfg_multidrop),
    .accept(cfg_accept), .rd(rd_pulse), .rx_data(rx_data),
    .data_ready(data_ready), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun), .brk_seen(brk_seen), .addr_seen(addr_seen),
    .addr_irq(addr_irq)
  );

  AST_BREAK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    brk_seen |-> err_frame); // R7
endmodule

// File: tb/uart_addr_rx_tb.sv
module uart_addr_rx_tb;
  localparam int BIT_CLKS = 64;

  logic       clk, rst_n, tick16, rxd;
  logic [1:0] cfg_len;
  logic       cfg_par_en, cfg_par_odd, cfg_multidrop, cfg_accept, rd_pulse;
  logic [7:0] rx_data;
  logic       data_ready, err_frame, err_parity, err_overrun, brk_seen, addr_seen, addr_irq;
  logic [1:0] tdiv;
  int         n_chk, n_bad, cyc;

  uart_addr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_multidrop(cfg_multidrop),
    .cfg_accept(cfg_accept), .rd_pulse(rd_pulse), .rx_data(rx_data),
    .data_ready(data_ready), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun), .brk_seen(brk_seen), .addr_seen(addr_seen),
    .addr_irq(addr_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdiv <= '0;
      tick16 <= 1'b0;
    end else begin
      tdiv <= tdiv + 1'b1;
      tick16 <= (tdiv == 2'd3);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit has_p,
                      input logic pv, input logic stopv);
    bit_out(1'b0, BIT_CLKS);
    for (int i = 0; i < nb; i++) bit_out(d[i], BIT_CLKS);
    if (has_p) bit_out(pv, BIT_CLKS);
    bit_out(stopv, BIT_CLKS);
    bit_out(1'b1, 2*BIT_CLKS);
  endtask

  task automatic read_byte();
    rd_pulse = 1'b1;
    @(negedge clk);
    rd_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ready", data_ready, 0);
    chk("R1 data", rx_data, 0);
    chk("R1 flags", {err_frame, err_parity, err_overrun, brk_seen, addr_seen, addr_irq}, 0);
  endtask

  task automatic t_basic();
    cfg_len = 2'd3;
    send(8'hA5, 8, 0, 0, 1);
    chk("R2 data A5", rx_data, 8'hA5);
    chk("R2 ready", data_ready, 1);
    chk("R6 no frame err", err_frame, 0);
    read_byte();
    chk("R9 ready cleared", data_ready, 0);
    send(8'h3C, 8, 0, 0, 1);
    chk("R2 data 3C", rx_data, 8'h3C);
    read_byte();
  endtask

  task automatic t_short();
    cfg_len = 2'd0;
    send(8'hFF, 5, 0, 0, 1);
    chk("R3 5-bit upper zero", rx_data, 8'h1F);
    read_byte();
    cfg_len = 2'd2;
    send(8'h55, 7, 0, 0, 1);
    chk("R3 7-bit", rx_data, 8'h55);
    read_byte();
    cfg_len = 2'd3;
  endtask

  task automatic t_false_start();
    bit_out(1'b0, 16);
    bit_out(1'b1, 12*BIT_CLKS);
    chk("R4 glitch ignored", data_ready, 0);
    send(8'h5A, 8, 0, 0, 1);
    chk("R4 recovers", rx_data, 8'h5A);
    read_byte();
  endtask

  task automatic t_parity();
    cfg_par_en = 1'b1;
    cfg_par_odd = 1'b0;
    send(8'h07, 8, 1, 1'b1, 1);
    chk("R5 even good", err_parity, 0);
    read_byte();
    send(8'h07, 8, 1, 1'b0, 1);
    chk("R5 even bad", err_parity, 1);
    read_byte();
    chk("R9 parity cleared", err_parity, 0);
    cfg_par_odd = 1'b1;
    send(8'h07, 8, 1, 1'b0, 1);
    chk("R5 odd good", err_parity, 0);
    read_byte();
    send(8'h03, 8, 1, 1'b0, 1);
    chk("R5 odd bad", err_parity, 1);
    read_byte();
    cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0;
  endtask

  task automatic t_frame();
    send(8'h81, 8, 0, 0, 0);
    chk("R6 frame err", err_frame, 1);
    chk("R6 data kept", rx_data, 8'h81);
    chk("R7 not break", brk_seen, 0);
    read_byte();
  endtask

  task automatic t_break();
    bit_out(1'b0, 14*BIT_CLKS);
    bit_out(1'b1, 3*BIT_CLKS);
    chk("R7 break", brk_seen, 1);
    chk("R7 frame err", err_frame, 1);
    chk("R7 data zero", rx_data, 0);
    chk("R7 single byte", err_overrun, 0);
    read_byte();
    chk("R9 break cleared", {brk_seen, err_frame}, 0);
  endtask

  task automatic t_overrun();
    send(8'h11, 8, 0, 0, 1);
    send(8'h22, 8, 0, 0, 1);
    chk("R8 overrun", err_overrun, 1);
    chk("R8 old byte kept", rx_data, 8'h11);
    read_byte();
    chk("R9 overrun cleared", {err_overrun, data_ready}, 0);
  endtask

  task automatic t_multidrop();
    cfg_multidrop = 1'b1;
    cfg_accept = 1'b0;
    send(8'h40, 8, 1, 1'b0, 1);
    chk("R11 data dropped", data_ready, 0);
    send(8'h12, 8, 1, 1'b1, 1);
    chk("R10 addr irq", addr_irq, 1);
    chk("R10 addr seen", addr_seen, 1);
    chk("R10 addr byte", rx_data, 8'h12);
    chk("R10 no parity err", err_parity, 0);
    read_byte();
    chk("R9 irq cleared", addr_irq, 0);
    cfg_accept = 1'b1;
    send(8'h55, 8, 1, 1'b0, 1);
    chk("R11 data accepted", data_ready, 1);
    chk("R11 data value", rx_data, 8'h55);
    chk("R11 not address", {addr_seen, addr_irq}, 0);
    read_byte();
    cfg_multidrop = 1'b0;
    cfg_accept = 1'b0;
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    cyc = 0;
    rst_n = 1'b0;
    rxd = 1'b1;
    cfg_len = 2'd3;
    cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0;
    cfg_multidrop = 1'b0;
    cfg_accept = 1'b0;
    rd_pulse = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_short();
    t_false_start();
    t_parity();
    t_frame();
    t_break();
    t_overrun();
    t_multidrop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule